// File: doc/BRIEF.md
# Signal Degrade Clearance Monitor

This block decides when an active signal-degrade condition on a received section-layer signal may be withdrawn. While the degrade flag is up it sums the per-frame parity byte error counts delivered by the framer and counts millisecond ticks. Each monitoring window lasts a programmable number of milliseconds. At the end of each window the error sum is compared with a clear threshold. When the sum is strictly below the threshold, the block emits a one-cycle clear pulse and drops its degrade flag. Otherwise a fresh window begins straight away.

The window length is a 24-bit millisecond count held in three byte-wide read/write registers. The framer that produces the error counts supplies them, together with a frame strobe. A separate declaring function raises the degrade flag through a one-cycle declare input.

Top module: `sdcm_top`

## Requirements
- R1: The three window bytes are readable and writable at addresses 0, 1 and 2. Address 0 holds bits 7:0 of the window value, address 1 holds bits 15:8 and address 2 holds bits 23:16. Each byte resets to 0xFF. The degrade flag and the clear pulse reset to 0.
- R2: A window of N milliseconds ends on the N-th millisecond tick counted from the start of that window.
- R3: While the degrade flag is high, every frame strobe adds its error count to the window total.
- R4: At the end of a window the block clears only when the total is strictly less than the threshold. A total equal to the threshold does not clear.
- R5: A one-cycle pulse on the declare input raises the degrade flag on the next cycle. The clear is a pulse of exactly one cycle, and the degrade flag is low in the same cycle as that pulse.
- R6: When a window ends without a clear, the total and the millisecond count return to zero and the next window starts at once.
- R7: While the degrade flag is low, ticks and frame errors have no effect. Monitoring therefore starts from zero when the flag is raised.
- R8: The error total saturates at its maximum value and does not wrap.
- R9: A window value of zero disables the decision, so no clear happens. A non-zero value written later takes effect without waiting for a window boundary.
- R10: A write to a window byte during a running window changes only the length of the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse each millisecond |
| frameValid | input | 1 | Strobe marking a valid frame error count |
| frameErrCnt | input | ERR_W | Parity byte errors found in that frame |
| sdDeclare | input | 1 | One-cycle request that raises the degrade flag |
| clrThresh | input | ACC_W | Clear threshold; a total below it clears |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register byte address (0 to 2) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for regAddr |
| sdFlag | output | 1 | Degrade condition currently active |
| sdClear | output | 1 | One-cycle pulse when the condition is cleared |

## Verification
The hardest case to reach is the point where a register write lands inside a running window. The new length must govern only the window that follows. To show this, the stimulus writes a shorter length after the first tick of a window and loads that window with errors at the threshold, so that it cannot clear. A clear pulse whose cycle number is predicted from the shorter length then shows that the change arrived exactly one window late. A narrow accumulator is built for the bench so that saturation can be driven from the ports. In that case, wrapping would produce a clear that does not belong there, and the scoreboard reports it as unexpected.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic monitor;  // degrade flag up: count ticks and errors
    logic restart;  // window boundary: zero counters, load new length
  } ctrlStrb_t;
endpackage

// File: rtl/sdcm_dp.sv
module sdcm_dp #(
  parameter int NUM_BYTES = 3,
  parameter int ACC_W     = 16,
  parameter int ERR_W     = 8,
  parameter int ADDR_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sdcm_pkg::ctrlStrb_t   ctrl,
  input  logic                  msTick,
  input  logic                  frameValid,
  input  logic [ERR_W-1:0]      frameErrCnt,
  input  logic [ACC_W-1:0]      clrThresh,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [7:0]            regWrData,
  output logic [7:0]            regRdData,
  output logic                  winEnd,
  output logic                  belowThr
);
  localparam int WIN_W = 8 * NUM_BYTES;
  localparam int SUM_W = ((ACC_W > ERR_W) ? ACC_W : ERR_W) + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic [7:0]       winByte [NUM_BYTES];
  logic [WIN_W-1:0] winReg;
  logic [WIN_W-1:0] activeWin;
  logic [WIN_W-1:0] msCnt;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] total;
  logic [SUM_W-1:0] rawSum;
  logic             winZero;

  // window byte registers, byte 0 least significant
  for (genvar i = 0; i < NUM_BYTES; i++) begin : gWinByte
    always_ff @(posedge clk) begin
      if (!rstN)
        winByte[i] <= 8'hFF;
      else if (regWrEn && regAddr == ADDR_W'(i))
        winByte[i] <= regWrData;
    end
    assign winReg[8*i +: 8] = winByte[i];
  end

  always_comb begin
    regRdData = 8'h00;
    for (int i = 0; i < NUM_BYTES; i++)
      if (regAddr == ADDR_W'(i)) regRdData = winByte[i];
  end

  // saturating running total including this cycle's frame
  always_comb begin
    rawSum = SUM_W'(acc);
    if (ctrl.monitor && frameValid)
      rawSum = SUM_W'(acc) + SUM_W'(frameErrCnt);
    total = (rawSum > SUM_W'(ACC_MAX)) ? ACC_MAX : rawSum[ACC_W-1:0];
  end

  assign winZero  = (activeWin == '0);
  assign winEnd   = ctrl.monitor && msTick && !winZero
                    && (msCnt == activeWin - WIN_W'(1));
  assign belowThr = (total < clrThresh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      msCnt     <= '0;
      activeWin <= '0;
    end else if (!ctrl.monitor || ctrl.restart) begin
      acc       <= '0;
      msCnt     <= '0;
      activeWin <= winReg;
    end else begin
      acc <= total;
      if (msTick && !winZero)
        msCnt <= msCnt + WIN_W'(1);
      if (winZero)
        activeWin <= winReg;
    end
  end

  // R2
  always @(posedge clk)
    win_bound_chk: assert property (disable iff (!rstN)
      !winZero |-> (msCnt < activeWin));

  // R8
  always @(posedge clk)
    acc_no_wrap_chk: assert property (disable iff (!rstN)
      (ctrl.monitor && !ctrl.restart) |=> (acc >= $past(acc)));

  // R7
  always @(posedge clk)
    idle_zero_chk: assert property (disable iff (!rstN)
      !ctrl.monitor |=> (acc == '0 && msCnt == '0));
endmodule

// File: rtl/sdcm_ctrl.sv
module sdcm_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdDeclare,
  input  logic                 winEnd,
  input  logic                 belowThr,
  output sdcm_pkg::ctrlStrb_t  ctrl,
  output logic                 sdFlag,
  output logic                 sdClear
);
  logic doClear;

  assign doClear      = sdFlag && winEnd && belowThr;
  assign ctrl.monitor = sdFlag;
  assign ctrl.restart = sdFlag && winEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdFlag  <= 1'b0;
      sdClear <= 1'b0;
    end else begin
      sdClear <= doClear;
      if (sdDeclare)
        sdFlag <= 1'b1;
      else if (doClear)
        sdFlag <= 1'b0;
    end
  end

  // R5
  always @(posedge clk)
    clear_drops_flag_chk: assert property (disable iff (!rstN)
      sdClear |-> (!sdFlag || $past(sdDeclare)) && $past(sdFlag));

  // R5
  always @(posedge clk)
    clear_single_chk: assert property (disable iff (!rstN)
      sdClear |=> !sdClear);

  // R4
  always @(posedge clk)
    clear_cause_chk: assert property (disable iff (!rstN)
      sdClear |-> $past(winEnd) && $past(belowThr));
endmodule

// File: rtl/sdcm_top.sv
module sdcm_top #(
  parameter int NUM_BYTES = 3,
  parameter int ACC_W     = 16,
  parameter int ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             frameValid,
  input  logic [ERR_W-1:0] frameErrCnt,
  input  logic             sdDeclare,
  input  logic [ACC_W-1:0] clrThresh,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  output logic             sdFlag,
  output logic             sdClear
);
  sdcm_pkg::ctrlStrb_t ctrl;
  logic winEnd;
  logic belowThr;

  sdcm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sdDeclare(sdDeclare), .winEnd(winEnd),
    .belowThr(belowThr), .ctrl(ctrl), .sdFlag(sdFlag), .sdClear(sdClear)
  );

  sdcm_dp #(.NUM_BYTES(NUM_BYTES), .ACC_W(ACC_W), .ERR_W(ERR_W), .ADDR_W(2)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .msTick(msTick),
    .frameValid(frameValid), .frameErrCnt(frameErrCnt), .clrThresh(clrThresh),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .winEnd(winEnd), .belowThr(belowThr)
  );
endmodule

// File: tb/tb_sdcm_top.sv
module tb_sdcm_top;
  localparam int ACC_W = 6;
  localparam int ERR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, frameValid = 1'b0, sdDeclare = 1'b0, regWrEn = 1'b0;
  logic [ERR_W-1:0] frameErrCnt = '0;
  logic [ACC_W-1:0] clrThresh = '0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic sdFlag, sdClear;

  int tests = 0, fails = 0;
  int cyc = 0;
  int expQ[$];
  bit done = 1'b0;

  sdcm_top #(.NUM_BYTES(3), .ACC_W(ACC_W), .ERR_W(ERR_W)) dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .frameValid(frameValid),
    .frameErrCnt(frameErrCnt), .sdDeclare(sdDeclare), .clrThresh(clrThresh),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .sdFlag(sdFlag), .sdClear(sdClear)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every clear pulse must match the next expected cycle
  always @(negedge clk) begin
    if (rstN && sdClear) begin
      if (expQ.size() == 0) begin
        check("R4/R6 unexpected clear", cyc, -1);
      end else begin
        check("R2 clear cycle", cyc, expQ.pop_front());
        check("R5 flag low with clear", int'(sdFlag), 0);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'(a); regWrData = 8'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string req);
    @(negedge clk);
    regAddr = 2'(a);
    #1 check(req, int'(regRdData), exp);
  endtask

  task automatic setWin(input int w);
    wr(0, w & 8'hFF); wr(1, (w >> 8) & 8'hFF); wr(2, (w >> 16) & 8'hFF);
  endtask

  task automatic declare();
    @(negedge clk);
    sdDeclare = 1'b1;
    @(negedge clk);
    sdDeclare = 1'b0;
    check("R5 flag raised", int'(sdFlag), 1);
  endtask

  task automatic frame(input int e);
    @(negedge clk);
    frameValid = 1'b1; frameErrCnt = 8'(e);
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  // driver: pushes the expected clear cycle when a tick should end the monitoring
  task automatic tick(input bit expClear);
    @(negedge clk);
    if (expClear) expQ.push_back(cyc + 1);
    msTick = 1'b1;
    @(negedge clk);
    msTick = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (3) @(negedge clk);
    check(req, expQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rd(0, 8'hFF, "R1 byte0 reset"); rd(1, 8'hFF, "R1 byte1 reset");
    rd(2, 8'hFF, "R1 byte2 reset");
    check("R1 flag reset", int'(sdFlag), 0);
    check("R1 clear reset", int'(sdClear), 0);

    // R1 byte order
    wr(0, 8'h04); wr(1, 8'h00); wr(2, 8'h00);
    rd(0, 8'h04, "R1 byte0 readback"); rd(2, 8'h00, "R1 byte2 readback");
    clrThresh = 6'd10;

    // R3 R4 below threshold: 9 errors, 4 ms window
    declare();
    frame(3); tick(0); frame(3); tick(0); frame(3); tick(0); tick(1);
    drain("R3 below threshold clears");
    check("R5 flag after clear", int'(sdFlag), 0);

    // R4 R6 equal threshold does not clear; next window clears
    declare();
    frame(4); frame(6); tick(0); tick(0); tick(0); tick(0);
    check("R6 flag stays after equal", int'(sdFlag), 1);
    tick(0); tick(0); tick(0); tick(1);
    drain("R6 next window clears");

    // R7 idle ticks and errors ignored
    frame(50); tick(0); tick(0); tick(0);
    check("R7 idle flag", int'(sdFlag), 0);
    declare();
    tick(0); tick(0); tick(0); tick(1);
    drain("R7 fresh start");

    // R8 saturation: 60+10 must stay at 63, not wrap to 6
    clrThresh = 6'd63;
    declare();
    frame(60); frame(10); tick(0); tick(0); tick(0); tick(0);
    check("R8 saturated no clear", int'(sdFlag), 1);
    tick(0); tick(0); tick(0); tick(1);
    drain("R8 saturation");
    clrThresh = 6'd10;

    // R9 zero window disables, later write applies
    setWin(0);
    declare();
    for (int i = 0; i < 10; i++) tick(0);
    check("R9 zero window no clear", int'(sdFlag), 1);
    wr(0, 8'h02);
    tick(0); tick(1);
    drain("R9 window enabled");

    // R10 write in running window applies to the next window
    setWin(4);
    declare();
    tick(0);
    wr(0, 8'h02);
    frame(12);
    tick(0); tick(0);
    check("R10 old length kept", int'(sdFlag), 1);
    tick(0);
    check("R10 window ended no clear", int'(sdFlag), 1);
    tick(0); tick(1);
    drain("R10 new length next window");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule